// File: doc/BRIEF.md
# Two-Level Interrupt Entry Controller

This block sits beside the fetch stage of a small processor core and decides, at each instruction boundary, whether the core leaves its current flow for a normal interrupt handler or a fast interrupt handler. Two level-sensitive request lines are weighed against the core's current mode and its two status mask bits. When an entry is granted, the block pulses a take strobe one cycle later and supplies the handler vector, the new mode, the new mask bits and the link value that the core writes into the link register of the target mode.

Each handler level owns a banked saved-status slot and a banked link slot inside the block. On entry, the status in force just before the entry and the link value are written into the slot of the level being entered. When the core issues an exception-return command, the block reads the slot of the current mode and drives the restored mode and masks plus the resume address (saved link minus four). The fast level can break into a running normal handler; a running fast handler holds off normal requests, because entry to either level masks normal requests and entry to the fast level masks fast requests as well.

Mode encoding used on every mode port: 2'b00 thread (no handler), 2'b01 normal handler, 2'b10 fast handler, 2'b11 reserved and treated like thread mode.

Top module: `ient_ctrl`

## Requirements
- R1: When both requests are high and both are unmasked at a boundary, the fast entry is taken and the normal one is not.
- R2: A granted entry raises `take_exc` for exactly the one cycle after the boundary cycle, with `redirect_pc` equal to 0x18 for a normal entry and 0x1C for a fast entry.
- R3: A normal request is granted only while `cur_imask` is 0; a fast request is granted only while `cur_fmask` is 0.
- R4: In the normal handler mode with `cur_fmask` 0, a fast request is granted; in the fast handler mode with both masks set, a normal request is not granted.
- R5: On a normal entry `new_mode` is 2'b01, `new_imask` is 1 and `new_fmask` equals the `cur_fmask` sampled at the boundary; on a fast entry `new_mode` is 2'b10 and both new masks are 1.
- R6: On any entry `link_val` equals `next_pc` sampled at the boundary plus 4.
- R7: An exception-return command in mode 2'b01 or 2'b10 raises `ret_exc` for one cycle, restores the mode and mask bits that were current before the most recent entry to that level, and sets `redirect_pc` to the link value saved by that entry minus 4.
- R8: Requests are ignored when `insn_bnd` is low and in a cycle carrying an exception-return command; an exception-return command in thread or reserved mode is ignored; `take_exc` and `ret_exc` are never high together.
- R9: After reset both `take_exc` and `ret_exc` are low and `redirect_pc` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| nrm_req | input | 1 | Level-sensitive normal interrupt request |
| fst_req | input | 1 | Level-sensitive fast interrupt request |
| cur_mode | input | 2 | Current processor mode |
| cur_imask | input | 1 | Status mask bit for normal requests (1 = masked) |
| cur_fmask | input | 1 | Status mask bit for fast requests (1 = masked) |
| next_pc | input | AW | Address of the next instruction to execute |
| insn_bnd | input | 1 | Instruction-boundary strobe, requests are sampled here |
| exc_ret | input | 1 | Exception-return command from the core |
| take_exc | output | 1 | One-cycle pulse: enter a handler |
| ret_exc | output | 1 | One-cycle pulse: return from a handler |
| redirect_pc | output | AW | Handler vector on entry, resume address on return |
| new_mode | output | 2 | Mode to adopt on entry or return |
| new_imask | output | 1 | Normal mask bit to adopt |
| new_fmask | output | 1 | Fast mask bit to adopt |
| link_val | output | AW | Value to write into the target mode's link register on entry |

## Verification
A wrong grant decision shows up one cycle after the boundary as a missing, extra or misrouted `take_exc` with the wrong vector, so the priority and mask logic is exposed immediately. A corrupted saved-status or link slot stays hidden until the matching exception-return, when it appears as a wrong restored mode, wrong masks or a resume address that does not point back at the interrupted instruction; the nested fast-over-normal sequence is the case that makes both slots visible in turn.

// File: rtl/ient_pkg.sv
package ient_pkg;

  typedef enum logic [1:0] {
    MODE_THR = 2'b00,
    MODE_NRM = 2'b01,
    MODE_FST = 2'b10,
    MODE_RSV = 2'b11
  } mode_e;

  typedef struct packed {
    mode_e mode;
    logic  imask;
    logic  fmask;
  } stat_t;

  localparam int NLVL    = 2;
  localparam int LVL_NRM = 0;
  localparam int LVL_FST = 1;

endpackage

// File: rtl/ient_arb.sv
module ient_arb (
  input  logic insn_bnd,
  input  logic exc_ret,
  input  logic nrm_req,
  input  logic fst_req,
  input  logic cur_imask,
  input  logic cur_fmask,
  output logic grant_nrm,
  output logic grant_fst
);

  logic sample_en;
  logic fst_ok;
  logic nrm_ok;

  always_comb begin
    sample_en = insn_bnd & ~exc_ret;
    fst_ok    = fst_req & ~cur_fmask;
    nrm_ok    = nrm_req & ~cur_imask;
    grant_fst = sample_en & fst_ok;
    grant_nrm = sample_en & nrm_ok & ~fst_ok;
  end

endmodule

// File: rtl/ient_bank.sv
module ient_bank
  import ient_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NLVL-1:0] wr_en,
  input  stat_t         wr_stat,
  input  logic [AW-1:0] wr_link,
  input  logic          rd_sel,
  output stat_t         rd_stat,
  output logic [AW-1:0] rd_link
);

  stat_t         stat_q [NLVL];
  logic [AW-1:0] link_q [NLVL];

  for (genvar g = 0; g < NLVL; g++) begin : g_lvl
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stat_q[g] <= '0;
        link_q[g] <= '0;
      end else if (wr_en[g]) begin
        stat_q[g] <= wr_stat;
        link_q[g] <= wr_link;
      end
    end
  end

  always_comb begin
    rd_stat = stat_q[rd_sel];
    rd_link = link_q[rd_sel];
  end

endmodule

// File: rtl/ient_outreg.sv
module ient_outreg
  import ient_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take_d,
  input  logic          ret_d,
  input  logic [AW-1:0] redir_d,
  input  stat_t         stat_d,
  input  logic [AW-1:0] link_d,
  output logic          take_q,
  output logic          ret_q,
  output logic [AW-1:0] redir_q,
  output stat_t         stat_q,
  output logic [AW-1:0] link_q
);

  logic upd_en;

  always_comb upd_en = take_d | ret_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take_q <= 1'b0;
      ret_q  <= 1'b0;
    end else begin
      take_q <= take_d;
      ret_q  <= ret_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      redir_q <= '0;
      stat_q  <= '0;
    end else if (upd_en) begin
      redir_q <= redir_d;
      stat_q  <= stat_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      link_q <= '0;
    end else if (take_d) begin
      link_q <= link_d;
    end
  end

endmodule

// File: rtl/ient_ctrl.sv
module ient_ctrl
  import ient_pkg::*;
#(
  parameter int          AW       = 32,
  parameter logic [31:0] VEC_NRM  = 32'h0000_0018,
  parameter logic [31:0] VEC_FST  = 32'h0000_001C,
  parameter int          LINK_OFS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          nrm_req,
  input  logic          fst_req,
  input  logic [1:0]    cur_mode,
  input  logic          cur_imask,
  input  logic          cur_fmask,
  input  logic [AW-1:0] next_pc,
  input  logic          insn_bnd,
  input  logic          exc_ret,
  output logic          take_exc,
  output logic          ret_exc,
  output logic [AW-1:0] redirect_pc,
  output logic [1:0]    new_mode,
  output logic          new_imask,
  output logic          new_fmask,
  output logic [AW-1:0] link_val
);

  localparam logic [AW-1:0] VEC_N = AW'(VEC_NRM);
  localparam logic [AW-1:0] VEC_F = AW'(VEC_FST);
  localparam logic [AW-1:0] OFS   = AW'(LINK_OFS);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  always_comb rst_q = rst_sync_q[1];

  // grant decision
  logic grant_nrm;
  logic grant_fst;

  ient_arb i_arb (
    .insn_bnd  (insn_bnd),
    .exc_ret   (exc_ret),
    .nrm_req   (nrm_req),
    .fst_req   (fst_req),
    .cur_imask (cur_imask),
    .cur_fmask (cur_fmask),
    .grant_nrm (grant_nrm),
    .grant_fst (grant_fst)
  );

  // banked saved status and link
  stat_t           cur_stat;
  stat_t           bank_stat;
  logic [AW-1:0]   bank_link;
  logic [NLVL-1:0] bank_wr;
  logic [AW-1:0]   entry_link;
  logic            ret_mode_ok;
  logic            ret_go;

  always_comb begin
    cur_stat            = '{mode: mode_e'(cur_mode), imask: cur_imask, fmask: cur_fmask};
    entry_link          = next_pc + OFS;
    bank_wr             = '0;
    bank_wr[LVL_NRM]    = grant_nrm;
    bank_wr[LVL_FST]    = grant_fst;
    ret_mode_ok         = (cur_mode == MODE_NRM) || (cur_mode == MODE_FST);
    ret_go              = exc_ret & ret_mode_ok;
  end

  ient_bank #(.AW(AW)) i_bank (
    .clk     (clk),
    .rst_n   (rst_q),
    .wr_en   (bank_wr),
    .wr_stat (cur_stat),
    .wr_link (entry_link),
    .rd_sel  (cur_mode == MODE_FST),
    .rd_stat (bank_stat),
    .rd_link (bank_link)
  );

  // next-state for the outputs
  logic          take_d;
  logic [AW-1:0] redir_d;
  stat_t         stat_d;

  always_comb begin
    take_d  = grant_nrm | grant_fst;
    redir_d = '0;
    stat_d  = cur_stat;
    if (grant_fst) begin
      redir_d = VEC_F;
      stat_d  = '{mode: MODE_FST, imask: 1'b1, fmask: 1'b1};
    end else if (grant_nrm) begin
      redir_d = VEC_N;
      stat_d  = '{mode: MODE_NRM, imask: 1'b1, fmask: cur_fmask};
    end else if (ret_go) begin
      redir_d = bank_link - OFS;
      stat_d  = bank_stat;
    end
  end

  stat_t out_stat;

  ient_outreg #(.AW(AW)) i_out (
    .clk     (clk),
    .rst_n   (rst_q),
    .take_d  (take_d),
    .ret_d   (ret_go),
    .redir_d (redir_d),
    .stat_d  (stat_d),
    .link_d  (entry_link),
    .take_q  (take_exc),
    .ret_q   (ret_exc),
    .redir_q (redirect_pc),
    .stat_q  (out_stat),
    .link_q  (link_val)
  );

  always_comb begin
    new_mode  = out_stat.mode;
    new_imask = out_stat.imask;
    new_fmask = out_stat.fmask;
  end

  // checks on port behaviour
  AST_FAST_WINS: assert property (@(posedge clk) disable iff (!rst_q)
    (insn_bnd && !exc_ret && fst_req && !cur_fmask) |=> (take_exc && redirect_pc == VEC_F)); // R1

  AST_NRM_UNMASKED: assert property (@(posedge clk) disable iff (!rst_q)
    (take_exc && new_mode == 2'b01) |-> $past(!cur_imask)); // R3

  AST_FST_UNMASKED: assert property (@(posedge clk) disable iff (!rst_q)
    (take_exc && new_mode == 2'b10) |-> $past(!cur_fmask)); // R3

  AST_ENTRY_SETS_I: assert property (@(posedge clk) disable iff (!rst_q)
    take_exc |-> new_imask); // R5

  AST_LINK_OFFSET: assert property (@(posedge clk) disable iff (!rst_q)
    take_exc |-> (link_val == $past(next_pc) + OFS)); // R6

  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_q)
    !(take_exc && ret_exc)); // R8

  AST_BND_ONLY: assert property (@(posedge clk) disable iff (!rst_q)
    $past(!insn_bnd || exc_ret) |-> !take_exc); // R8

  AST_THR_RET_IGNORED: assert property (@(posedge clk) disable iff (!rst_q)
    $past(cur_mode == 2'b00 || cur_mode == 2'b11) |-> !ret_exc); // R8

endmodule

// File: tb/test_ient_ctrl.sv
`timescale 1ns/1ps
module test_ient_ctrl;

  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          nrm_req, fst_req;
  logic [1:0]    cur_mode;
  logic          cur_imask, cur_fmask;
  logic [AW-1:0] next_pc;
  logic          insn_bnd, exc_ret;
  logic          take_exc, ret_exc;
  logic [AW-1:0] redirect_pc;
  logic [1:0]    new_mode;
  logic          new_imask, new_fmask;
  logic [AW-1:0] link_val;

  int nchk = 0;
  int nerr = 0;

  always #2 clk = ~clk;

  ient_ctrl #(.AW(AW)) i_ient_ctrl (
    .clk(clk), .rst_n(rst_n), .nrm_req(nrm_req), .fst_req(fst_req),
    .cur_mode(cur_mode), .cur_imask(cur_imask), .cur_fmask(cur_fmask),
    .next_pc(next_pc), .insn_bnd(insn_bnd), .exc_ret(exc_ret),
    .take_exc(take_exc), .ret_exc(ret_exc), .redirect_pc(redirect_pc),
    .new_mode(new_mode), .new_imask(new_imask), .new_fmask(new_fmask),
    .link_val(link_val)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // apply one cycle of stimulus, return at the negedge after the capturing edge
  task automatic drive(input logic fr, input logic nr, input logic [1:0] m,
                       input logic im, input logic fm, input logic [AW-1:0] pc,
                       input logic bnd, input logic ret);
    @(negedge clk);
    fst_req = fr; nrm_req = nr; cur_mode = m; cur_imask = im; cur_fmask = fm;
    next_pc = pc; insn_bnd = bnd; exc_ret = ret;
    @(posedge clk);
    @(negedge clk);
    fst_req = 1'b0; nrm_req = 1'b0; insn_bnd = 1'b0; exc_ret = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog act=running exp=done");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; nrm_req = 0; fst_req = 0; cur_mode = 0; cur_imask = 0;
    cur_fmask = 0; next_pc = 0; insn_bnd = 0; exc_ret = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R9 take", take_exc, 0);
    chk("R9 ret", ret_exc, 0);
    chk("R9 redirect", redirect_pc, 0);

    // sweep: mode x requests x masks x boundary x return
    for (int k = 0; k < 192; k++) begin
      logic [1:0] m;
      logic [5:0] b;
      logic [AW-1:0] pc;
      logic fok, nok, smp, exp_f, exp_n, exp_r;
      m  = 2'(k % 3);
      b  = 6'(k / 3);
      pc = AW'(32'h1000 + k * 8);
      drive(b[0], b[1], m, b[2], b[3], pc, b[4], b[5]);
      smp   = b[4] & ~b[5];
      fok   = b[0] & ~b[3];
      nok   = b[1] & ~b[2];
      exp_f = smp & fok;
      exp_n = smp & nok & ~fok;
      exp_r = b[5] & (m != 2'b00);
      chk("R8 take", take_exc, exp_f | exp_n);
      chk("R8 ret", ret_exc, exp_r);
      if (exp_f) begin
        chk("R1 R2 vec fast", redirect_pc, 32'h1C);
        chk("R5 mode fast", new_mode, 2'b10);
        chk("R5 masks fast", {new_imask, new_fmask}, 2'b11);
        chk("R6 link", link_val, pc + 4);
      end
      if (exp_n) begin
        chk("R2 R3 vec normal", redirect_pc, 32'h18);
        chk("R5 mode normal", new_mode, 2'b01);
        chk("R5 masks normal", {new_imask, new_fmask}, {1'b1, b[3]});
        chk("R6 link", link_val, pc + 4);
      end
    end

    // nested: normal entry, fast pre-emption, held-off normal, unwinding
    drive(0, 1, 2'b00, 0, 0, 32'h100, 1, 0);
    chk("R2 take normal", take_exc, 1);
    chk("R2 vec normal", redirect_pc, 32'h18);
    chk("R6 link normal", link_val, 32'h104);
    drive(1, 0, 2'b01, 1, 0, 32'h200, 1, 0);
    chk("R4 preempt take", take_exc, 1);
    chk("R4 preempt vec", redirect_pc, 32'h1C);
    chk("R4 preempt mode", new_mode, 2'b10);
    chk("R6 link fast", link_val, 32'h204);
    drive(0, 1, 2'b10, 1, 1, 32'h300, 1, 0);
    chk("R4 normal waits", take_exc, 0);
    drive(0, 0, 2'b10, 1, 1, 32'h300, 0, 1);
    chk("R7 ret fast pulse", ret_exc, 1);
    chk("R7 ret fast pc", redirect_pc, 32'h200);
    chk("R7 ret fast mode", new_mode, 2'b01);
    chk("R7 ret fast masks", {new_imask, new_fmask}, 2'b10);
    drive(0, 0, 2'b01, 1, 0, 32'h300, 0, 1);
    chk("R7 ret normal pulse", ret_exc, 1);
    chk("R7 ret normal pc", redirect_pc, 32'h100);
    chk("R7 ret normal mode", new_mode, 2'b00);
    chk("R7 ret normal masks", {new_imask, new_fmask}, 2'b00);

    // return in thread mode is ignored
    drive(1, 1, 2'b00, 0, 0, 32'h400, 0, 1);
    chk("R8 thread ret", ret_exc, 0);
    chk("R8 thread ret take", take_exc, 0);
    // return wins over a boundary in the same cycle
    drive(1, 1, 2'b01, 0, 0, 32'h500, 1, 1);
    chk("R8 ret suppresses take", take_exc, 0);
    chk("R8 ret pulse", ret_exc, 1);
    chk("R7 ret pc again", redirect_pc, 32'h100);

    // normal entry keeps F, return restores it
    drive(0, 1, 2'b00, 0, 1, 32'h600, 1, 0);
    chk("R5 normal keeps F", {new_imask, new_fmask}, 2'b11);
    chk("R5 mode normal", new_mode, 2'b01);
    drive(0, 0, 2'b01, 1, 1, 32'h0, 0, 1);
    chk("R7 restore F", {new_mode, new_imask, new_fmask}, 4'b0001);
    chk("R7 restore pc", redirect_pc, 32'h600);

    // both pending, both unmasked
    drive(1, 1, 2'b00, 0, 0, 32'h700, 1, 0);
    chk("R1 fast chosen", redirect_pc, 32'h1C);
    @(negedge clk);
    chk("R2 single pulse", take_exc, 0);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule